// File: doc/BRIEF.md
# Bit Alias Address Translator

This block sits between a 32-bit bus master and a word-wide, byte-addressed synchronous memory. A window of the bus address space is set aside as a bit alias window. Every 32-bit word in that window stands for one bit of a byte in a target region of memory. A store to such a word becomes an atomic single-bit update of the target byte. A load from it returns that bit as a 0 or 1 word. Accesses outside the window are forwarded to the memory unchanged.

An alias word's offset from the window base encodes the target in two parts. The target byte offset is scaled by 32, and the bit number, 0 to 7, is scaled by 4. The target byte offset is `OFFS_W` bits wide, which is 10 by default, so the window reaches 1 KB of target bytes.

An alias store is done as a memory read of the containing word followed by a write of the merged byte. The bus ready is held low for the extra cycle, and no other memory access comes between the read and the write. Software therefore never has to do its own read-modify-write.

Top module: `bitband_xlate`

## Requirements
- R1: A bus write outside the alias window issues one memory write in the same cycle, with the same address, data and byte enables. Bus ready is high in that cycle.
- R2: A bus read outside the alias window issues a memory read in its first cycle. Bus ready goes high in the second cycle, and the read data is the memory word.
- R3: An address is inside the alias window when it lies in [ALIAS_BASE, ALIAS_BASE + 2^(OFFS_W+5)). The target byte is TARGET_BASE + addr[OFFS_W+4:5], the bit number is addr[4:2], and addr[1:0] is ignored.
- R4: In an alias write, only bit 0 of the write data counts. A 1 sets the target bit and a 0 clears it. The other write data bits and the bus byte enables have no effect.
- R5: An alias write leaves every other bit of the target byte unchanged, and every other byte of the memory word as well. The memory write enables only the target byte lane.
- R6: An alias read completes in two cycles. It returns exactly 0x00000001 when the target bit is set and 0x00000000 when it is clear, and it performs no memory write.
- R7: An alias write takes two cycles. In the first, a memory read of the word holding the target byte is issued and bus ready is low. In the second, the merged byte is written and bus ready is high. No other memory access occurs between the two.
- R8: Reset is asynchronous. It returns the sequencer to idle at once, and any alias write in flight is dropped without a memory write. While the block is idle with no request, the memory enable is low.
- R9: The addresses one word below the window and one word past its end are handled as plain accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| bus_valid | input | 1 | Request present; held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for plain writes |
| bus_ready | output | 1 | Request completes this cycle |
| bus_rdata | output | 32 | Read data, valid when bus_ready on a read |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read strobe |

## Verification
The hardest situation to reach from the ports is a reset that arrives between the read and the write-back of an alias store. At that point the half-finished merge must be discarded rather than written. The bench starts an alias store and raises reset at the negative edge after the memory read has been issued. It then reads the target word back through a plain access to show that it is unchanged. The window edges are covered by plain writes one word below and one word past the window, with the memory address that was issued compared against the bus address.

// File: rtl/bitband_xlate.sv
module bitband_xlate #(
  parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000,
  parameter logic [31:0] TARGET_BASE = 32'h2000_0000,
  parameter int          OFFS_W      = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_be,
  output logic        bus_ready,
  output logic [31:0] bus_rdata,
  output logic        mem_en,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int HI = OFFS_W + 5;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_PRD = 2'd1, S_ARD = 2'd2, S_AMRG = 2'd3} st_t;
  st_t state, nxt;

  logic              hit;
  logic [OFFS_W-1:0] byte_off;
  logic [31:0]       tgt;
  logic [1:0]        lane_q;
  logic [2:0]        bit_q;
  logic              val_q;
  logic [31:0]       waddr_q;
  logic [7:0]        cur_byte, merged;

  assign hit      = bus_addr[31:HI] == ALIAS_BASE[31:HI];
  assign byte_off = bus_addr[HI-1:5];
  assign tgt      = TARGET_BASE + {{(32-OFFS_W){1'b0}}, byte_off};
  assign cur_byte = mem_rdata[lane_q*8 +: 8];

  always_comb begin
    merged = cur_byte;
    merged[bit_q] = val_q;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state   <= S_IDLE;
      lane_q  <= '0;
      bit_q   <= '0;
      val_q   <= 1'b0;
      waddr_q <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && bus_valid && hit) begin
        lane_q  <= tgt[1:0];
        bit_q   <= bus_addr[4:2];
        val_q   <= bus_wdata[0];
        waddr_q <= {tgt[31:2], 2'b00};
      end
    end
  end

  always_comb begin
    nxt       = state;
    bus_ready = 1'b0;
    bus_rdata = '0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = bus_addr;
    mem_be    = bus_be;
    mem_wdata = bus_wdata;
    unique case (state)
      S_IDLE: if (bus_valid) begin
        mem_en = 1'b1;
        if (hit) begin
          mem_addr = {tgt[31:2], 2'b00};
          mem_be   = 4'hF;
          nxt      = bus_write ? S_AMRG : S_ARD;
        end else if (bus_write) begin
          mem_we    = 1'b1;
          bus_ready = 1'b1;
        end else begin
          nxt = S_PRD;
        end
      end
      S_PRD: begin
        bus_ready = 1'b1;
        bus_rdata = mem_rdata;
        nxt       = S_IDLE;
      end
      S_ARD: begin
        bus_ready = 1'b1;
        bus_rdata = {31'b0, cur_byte[bit_q]};
        nxt       = S_IDLE;
      end
      S_AMRG: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = waddr_q;
        mem_be    = 4'b0001 << lane_q;
        mem_wdata = {4{merged}};
        bus_ready = 1'b1;
        nxt       = S_IDLE;
      end
    endcase
  end
endmodule

module bitband_xlate_chk #(
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          OFFS_W     = 10
) (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  st,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [31:0] bus_addr,
  input logic        bus_ready,
  input logic [31:0] bus_rdata,
  input logic        mem_en,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be
);
  localparam int HI = OFFS_W + 5;
  logic in_win, idle_req;
  assign in_win   = bus_addr[31:HI] == ALIAS_BASE[31:HI];
  assign idle_req = st == 2'd0 && bus_valid;

  AST_ALIAS_WR_FIRST: assert property (@(posedge clk) disable iff (rst)
    idle_req && bus_write && in_win |-> mem_en && !mem_we && !bus_ready); // R7
  AST_ALIAS_WR_MERGE: assert property (@(posedge clk) disable iff (rst)
    idle_req && bus_write && in_win |=> mem_en && mem_we && $onehot(mem_be) && bus_ready); // R5
  AST_ALIAS_RD_BIT: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_ready && !bus_write && in_win |-> bus_rdata[31:1] == 31'b0); // R6
  AST_ALIAS_RD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    idle_req && !bus_write && in_win |=> !(mem_en && mem_we)); // R6
  AST_PASS_WRITE: assert property (@(posedge clk) disable iff (rst)
    idle_req && bus_write && !in_win |-> mem_en && mem_we && mem_addr == bus_addr && bus_ready); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    st == 2'd0 && !bus_valid |-> !mem_en && !bus_ready); // R8
endmodule

bind bitband_xlate bitband_xlate_chk #(.ALIAS_BASE(ALIAS_BASE), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rst(rst), .st(state), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_ready(bus_ready), .bus_rdata(bus_rdata), .mem_en(mem_en),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be)
);

// File: tb/bitband_xlate_bench.sv
module bitband_xlate_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [3:0] bus_be = '0;
  logic bus_ready, mem_en, mem_we;
  logic [31:0] bus_rdata, mem_addr, mem_wdata, mem_rdata, last_wr_addr;
  logic [3:0] mem_be;
  logic [31:0] mem [0:255];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bitband_xlate u_bitband_xlate (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_en && mem_we) begin
      last_wr_addr <= mem_addr;
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mem[mem_addr[9:2]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
    end else if (mem_en) begin
      mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_be = be;
    cyc = 1;
    forever begin
      #1;
      if (bus_ready) begin rd = bus_rdata; @(posedge clk); break; end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R8 ready in reset", {31'b0, bus_ready}, 32'd0);
    chk("R8 mem_en in reset", {31'b0, mem_en}, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    chk("R8 mem_en idle", {31'b0, mem_en}, 32'd0);
  endtask

  task automatic t_plain;
    logic [31:0] rd; int cyc;
    xfer(1, 32'h2000_0010, 32'hF5F5_F5F5, 4'hF, rd, cyc);
    chk("R1 write cycles", cyc, 1);
    chk("R1 write address", last_wr_addr, 32'h2000_0010);
    xfer(1, 32'h2000_0014, 32'hAABB_CCDD, 4'b0100, rd, cyc);
    xfer(0, 32'h2000_0010, 0, 0, rd, cyc);
    chk("R2 read cycles", cyc, 2);
    chk("R2 read data", rd, 32'hF5F5_F5F5);
    xfer(0, 32'h2000_0014, 0, 0, rd, cyc);
    chk("R1 byte enables", rd & 32'h00FF_0000, 32'h00BB_0000);
  endtask

  task automatic t_alias_write;
    logic [31:0] rd; int cyc;
    xfer(1, 32'h2200_022C, 32'h0000_0001, 4'h0, rd, cyc);
    chk("R7 alias write cycles", cyc, 2);
    xfer(0, 32'h2000_0010, 0, 0, rd, cyc);
    chk("R5 set bit3 of byte 0x11", rd, 32'hF5F5_FDF5);
    xfer(1, 32'h2200_0220, 32'hFFFF_FFFE, 4'hF, rd, cyc);
    xfer(0, 32'h2000_0010, 0, 0, rd, cyc);
    chk("R4 clear via bit0 only", rd, 32'hF5F5_FCF5);
    xfer(1, 32'h2200_0220, 32'h0000_0001, 4'hF, rd, cyc);
    xfer(0, 32'h2000_0010, 0, 0, rd, cyc);
    chk("R4 set bit0", rd, 32'hF5F5_FDF5);
  endtask

  task automatic t_alias_read;
    logic [31:0] rd; int cyc;
    xfer(0, 32'h2200_022E, 0, 0, rd, cyc);
    chk("R3 low bits ignored, bit set", rd, 32'h0000_0001);
    chk("R6 alias read cycles", cyc, 2);
    xfer(0, 32'h2200_0224, 0, 0, rd, cyc);
    chk("R6 bit clear reads zero", rd, 32'h0000_0000);
    xfer(0, 32'h2000_0010, 0, 0, rd, cyc);
    chk("R6 no change after read", rd, 32'hF5F5_FDF5);
  endtask

  task automatic t_edges;
    logic [31:0] rd; int cyc;
    xfer(1, 32'h2000_03FC, 32'h0000_0000, 4'hF, rd, cyc);
    xfer(1, 32'h2200_7FFC, 32'h1, 4'h0, rd, cyc);
    chk("R3 last alias word", last_wr_addr, 32'h2000_03FC);
    xfer(0, 32'h2000_03FC, 0, 0, rd, cyc);
    chk("R3 top bit of last byte", rd, 32'h8000_0000);
    xfer(1, 32'h2200_8000, 32'h1234_5678, 4'hF, rd, cyc);
    chk("R9 past window cycles", cyc, 1);
    chk("R9 past window address", last_wr_addr, 32'h2200_8000);
    xfer(1, 32'h21FF_FFFC, 32'h0000_0000, 4'hF, rd, cyc);
    chk("R9 below window address", last_wr_addr, 32'h21FF_FFFC);
  endtask

  task automatic t_reset_inflight;
    logic [31:0] rd; int cyc;
    xfer(1, 32'h2000_0020, 32'h0, 4'hF, rd, cyc);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 32'h2200_0404; bus_wdata = 32'h1;
    @(posedge clk); @(negedge clk);
    rst = 1'b1; bus_valid = 1'b0;
    #1;
    chk("R8 no write after reset", {31'b0, mem_en}, 32'd0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    xfer(0, 32'h2000_0020, 0, 0, rd, cyc);
    chk("R8 dropped write", rd, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    t_reset;
    t_plain;
    t_alias_write;
    t_alias_read;
    t_edges;
    t_reset_inflight;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule